// File: doc/BRIEF.md
# Two-Level Interrupt Entry Sequencer

This block moves a processor from normal execution into an interrupt handler and back. It holds the architectural program counter, code segment register and 8-bit status word. It accepts three kinds of request: a maskable line, a non-maskable line and a software-trigger strobe that carries its own vector index. For each accepted request it saves the current context into one of two shadow banks, one step per clock. It then updates the enable flag and the exception-level field and loads the handler address from an internal vector table.

A return strobe restores the saved context from the bank that matches the current exception level. The surrounding core writes the architectural registers through a load port while the sequencer is idle. Software fills the vector table through a simple write port. Requests that cannot be served right away are held pending until they can.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, pc, csr and psw read zero, busy and ack are low, and no request is pending.
- R2: The status word keeps the enable flag in bit 3 and the level code in bits 1:0 (0 = none, 1 = bank-one level, 2 = bank-two level). A maskable request is taken only while the enable flag is 1. Otherwise it stays pending and is taken once the flag becomes 1.
- R3: A maskable entry keeps busy high for 6 cycles. In order, it saves pc, csr and the unmodified psw to bank one, clears the enable flag, sets the level to 1, and loads pc from the vector table at slot MASK_SLOT (default 2).
- R4: A non-maskable entry is taken whatever the enable flag is. It keeps busy high for 5 cycles, saves into bank two, sets the level to 2, leaves the enable flag unchanged, and loads pc from slot NMI_SLOT (default 1).
- R5: A non-maskable request is not accepted while the level is 2. It stays pending and is taken once the level leaves 2.
- R6: A software trigger is taken whatever the enable flag is. It follows the maskable sequence (bank one, flag cleared, level 1, 6 busy cycles) and loads pc from the table slot given by its index. A second trigger that arrives while one is already pending is dropped.
- R7: When requests are eligible together, the non-maskable one is served first, then the software one, then the maskable one. The others stay pending.
- R8: ack is high for exactly the one cycle in which the newly loaded pc first appears. pc and csr do not change while busy is high, except for that pc load.
- R9: In an idle cycle with level 1, a return strobe restores pc, csr and psw from bank one in a single cycle. With level 2 it restores from bank two. The strobe is ignored at level 0 and while busy, and no request is accepted in the cycle a return is taken.
- R10: The architectural load port is honoured only in idle cycles in which neither an entry nor a return is taken. Vector table writes take effect for every later entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | Non-maskable request pulse |
| irq_req | input | 1 | Maskable request pulse |
| swi_stb | input | 1 | Software-trigger strobe |
| swi_idx | input | IDX_W | Vector slot used by the software trigger |
| rti_stb | input | 1 | Return-from-interrupt strobe |
| arch_we | input | 1 | Load the architectural registers |
| arch_pc | input | PC_W | Program counter load value |
| arch_csr | input | CSR_W | Code segment load value |
| arch_psw | input | 8 | Status word load value |
| vt_we | input | 1 | Vector table write enable |
| vt_addr | input | IDX_W | Vector table write slot |
| vt_data | input | PC_W | Handler start address to store |
| pc | output | PC_W | Current program counter |
| csr | output | CSR_W | Current code segment register |
| psw | output | 8 | Current status word |
| busy | output | 1 | Entry sequence in progress |
| ack | output | 1 | One-cycle pulse when the handler address is loaded |

## Verification
The bench builds the block with its defaults: a 16-bit pc, an 8-bit csr and a 64-slot table with the non-maskable and maskable slots at 1 and 2. That lets the software trigger reach both ends of the table (slots 0 and 63) and gives distinct handler addresses for each source. The behavioural model follows the level field through nested chains, such as a non-maskable entry followed by a software entry and a deferred maskable one, so the bank choice and the restore order on return are compared every cycle.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int PSW_W    = 8;
    localparam int MIE_POS  = 3;
    localparam int LVL_LO   = 0;
    localparam int NUM_BANK = 2;

    localparam logic [1:0] LVL_NONE = 2'd0;
    localparam logic [1:0] LVL_ONE  = 2'd1;
    localparam logic [1:0] LVL_TWO  = 2'd2;

    typedef enum logic [1:0] {
        SRC_MASK = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_SOFT = 2'd2
    } src_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SAVE_PC  = 3'd1,
        ST_SAVE_CSR = 3'd2,
        ST_SAVE_PSW = 3'd3,
        ST_CLR_MIE  = 3'd4,
        ST_SET_LVL  = 3'd5,
        ST_LOAD_PC  = 3'd6
    } step_e;

    function automatic logic [1:0] lvl_of(input logic [PSW_W-1:0] p);
        return p[LVL_LO +: 2];
    endfunction

    function automatic logic mie_of(input logic [PSW_W-1:0] p);
        return p[MIE_POS];
    endfunction

    function automatic logic [PSW_W-1:0] with_lvl(input logic [PSW_W-1:0] p,
                                                  input logic [1:0] l);
        logic [PSW_W-1:0] r;
        r = p;
        r[LVL_LO +: 2] = l;
        return r;
    endfunction

    function automatic logic [PSW_W-1:0] without_mie(input logic [PSW_W-1:0] p);
        logic [PSW_W-1:0] r;
        r = p;
        r[MIE_POS] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (we) begin
            slot_q[waddr] <= wdata;
        end
    end

    assign rdata = slot_q[raddr];
endmodule

// File: rtl/irq_ctx_bank.sv
module irq_ctx_bank
    import irq_seq_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int CSR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             save_pc,
    input  logic             save_csr,
    input  logic             save_psw,
    input  logic [PC_W-1:0]  pc_d,
    input  logic [CSR_W-1:0] csr_d,
    input  logic [PSW_W-1:0] psw_d,
    output logic [PC_W-1:0]  pc_q,
    output logic [CSR_W-1:0] csr_q,
    output logic [PSW_W-1:0] psw_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            csr_q <= '0;
            psw_q <= '0;
        end else begin
            if (save_pc)  pc_q  <= pc_d;
            if (save_csr) csr_q <= csr_d;
            if (save_psw) psw_q <= psw_d;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_seq_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int NMI_SLOT  = 1,
    parameter int MASK_SLOT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nmi_req,
    input  logic             irq_req,
    input  logic             swi_stb,
    input  logic [IDX_W-1:0] swi_idx,
    input  logic             can_take,
    input  logic             mie,
    input  logic [1:0]       lvl,
    output logic             take,
    output src_e             take_src,
    output logic [IDX_W-1:0] take_idx
);
    logic             nmi_p, mask_p, soft_p;
    logic [IDX_W-1:0] soft_idx_q;
    logic             nmi_e, mask_e, soft_e;
    logic [IDX_W-1:0] soft_idx_e;
    logic             pick_nmi, pick_soft, pick_mask;

    always_comb begin
        nmi_e      = nmi_p | nmi_req;
        mask_e     = mask_p | irq_req;
        soft_e     = soft_p | swi_stb;
        soft_idx_e = soft_p ? soft_idx_q : swi_idx;

        pick_nmi   = can_take && nmi_e && (lvl != LVL_TWO);
        pick_soft  = can_take && !pick_nmi && soft_e;
        pick_mask  = can_take && !pick_nmi && !pick_soft && mask_e && mie;
        take       = pick_nmi | pick_soft | pick_mask;

        take_src = SRC_MASK;
        take_idx = IDX_W'(MASK_SLOT);
        if (pick_nmi) begin
            take_src = SRC_NMI;
            take_idx = IDX_W'(NMI_SLOT);
        end else if (pick_soft) begin
            take_src = SRC_SOFT;
            take_idx = soft_idx_e;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_p      <= 1'b0;
            mask_p     <= 1'b0;
            soft_p     <= 1'b0;
            soft_idx_q <= '0;
        end else begin
            nmi_p      <= nmi_e & ~pick_nmi;
            mask_p     <= mask_e & ~pick_mask;
            soft_p     <= soft_e & ~pick_soft;
            soft_idx_q <= soft_idx_e;
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int CSR_W     = 8,
    parameter int VT_DEPTH  = 64,
    parameter int NMI_SLOT  = 1,
    parameter int MASK_SLOT = 2,
    localparam int IDX_W    = $clog2(VT_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nmi_req,
    input  logic             irq_req,
    input  logic             swi_stb,
    input  logic [IDX_W-1:0] swi_idx,
    input  logic             rti_stb,
    input  logic             arch_we,
    input  logic [PC_W-1:0]  arch_pc,
    input  logic [CSR_W-1:0] arch_csr,
    input  logic [7:0]       arch_psw,
    input  logic             vt_we,
    input  logic [IDX_W-1:0] vt_addr,
    input  logic [PC_W-1:0]  vt_data,
    output logic [PC_W-1:0]  pc,
    output logic [CSR_W-1:0] csr,
    output logic [7:0]       psw,
    output logic             busy,
    output logic             ack
);
    step_e            step_q;
    src_e             src_q;
    logic [IDX_W-1:0] idx_q;
    logic [PC_W-1:0]  pc_q;
    logic [CSR_W-1:0] csr_q;
    logic [PSW_W-1:0] psw_q;
    logic             ack_q;

    logic             idle, rti_go, take;
    src_e             take_src;
    logic [IDX_W-1:0] take_idx;
    logic [PC_W-1:0]  vec_addr;
    logic             bank_sel, ret_sel;

    logic [PC_W-1:0]  bk_pc  [NUM_BANK];
    logic [CSR_W-1:0] bk_csr [NUM_BANK];
    logic [PSW_W-1:0] bk_psw [NUM_BANK];

    assign idle     = (step_q == ST_IDLE);
    assign rti_go   = idle && rti_stb && (lvl_of(psw_q) != LVL_NONE);
    assign bank_sel = (src_q == SRC_NMI);
    assign ret_sel  = (lvl_of(psw_q) != LVL_ONE);

    irq_arbiter #(
        .IDX_W     (IDX_W),
        .NMI_SLOT  (NMI_SLOT),
        .MASK_SLOT (MASK_SLOT)
    ) u_arb (
        .clk      (clk),
        .rst      (rst),
        .nmi_req  (nmi_req),
        .irq_req  (irq_req),
        .swi_stb  (swi_stb),
        .swi_idx  (swi_idx),
        .can_take (idle && !rti_go),
        .mie      (mie_of(psw_q)),
        .lvl      (lvl_of(psw_q)),
        .take     (take),
        .take_src (take_src),
        .take_idx (take_idx)
    );

    irq_vec_table #(
        .DEPTH  (VT_DEPTH),
        .DATA_W (PC_W)
    ) u_vt (
        .clk   (clk),
        .rst   (rst),
        .we    (vt_we),
        .waddr (vt_addr),
        .wdata (vt_data),
        .raddr (idx_q),
        .rdata (vec_addr)
    );

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        irq_ctx_bank #(
            .PC_W  (PC_W),
            .CSR_W (CSR_W)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .save_pc  (step_q == ST_SAVE_PC  && bank_sel == b[0]),
            .save_csr (step_q == ST_SAVE_CSR && bank_sel == b[0]),
            .save_psw (step_q == ST_SAVE_PSW && bank_sel == b[0]),
            .pc_d     (pc_q),
            .csr_d    (csr_q),
            .psw_d    (psw_q),
            .pc_q     (bk_pc[b]),
            .csr_q    (bk_csr[b]),
            .psw_q    (bk_psw[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= ST_IDLE;
            src_q  <= SRC_MASK;
            idx_q  <= '0;
            pc_q   <= '0;
            csr_q  <= '0;
            psw_q  <= '0;
            ack_q  <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            unique case (step_q)
                ST_IDLE: begin
                    if (rti_go) begin
                        pc_q  <= bk_pc[ret_sel];
                        csr_q <= bk_csr[ret_sel];
                        psw_q <= bk_psw[ret_sel];
                    end else if (take) begin
                        src_q  <= take_src;
                        idx_q  <= take_idx;
                        step_q <= ST_SAVE_PC;
                    end else if (arch_we) begin
                        pc_q  <= arch_pc;
                        csr_q <= arch_csr;
                        psw_q <= arch_psw;
                    end
                end
                ST_SAVE_PC:  step_q <= ST_SAVE_CSR;
                ST_SAVE_CSR: step_q <= ST_SAVE_PSW;
                ST_SAVE_PSW: step_q <= (src_q == SRC_NMI) ? ST_SET_LVL : ST_CLR_MIE;
                ST_CLR_MIE: begin
                    psw_q  <= without_mie(psw_q);
                    step_q <= ST_SET_LVL;
                end
                ST_SET_LVL: begin
                    psw_q  <= with_lvl(psw_q, (src_q == SRC_NMI) ? LVL_TWO : LVL_ONE);
                    step_q <= ST_LOAD_PC;
                end
                ST_LOAD_PC: begin
                    pc_q   <= vec_addr;
                    ack_q  <= 1'b1;
                    step_q <= ST_IDLE;
                end
                default: step_q <= ST_IDLE;
            endcase
        end
    end

    assign pc   = pc_q;
    assign csr  = csr_q;
    assign psw  = psw_q;
    assign busy = !idle;
    assign ack  = ack_q;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int PC_W  = 16,
    parameter int CSR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rti_stb,
    input logic [PC_W-1:0]  pc,
    input logic [CSR_W-1:0] csr,
    input logic [7:0]       psw,
    input logic             busy,
    input logic             ack
);
    // R8: acknowledge is a single-cycle pulse
    p_ack_single_r8: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R8: pc moves during entry only together with ack
    p_pc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (ack || $stable(pc)));

    // R8: csr never moves during entry
    p_csr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(csr));

    // R3 / R6: a level-one entry ends with the enable flag clear
    p_lvl1_mie_r3: assert property (@(posedge clk) disable iff (rst)
        (ack && psw[1:0] == 2'd1) |-> !psw[3]);

    // R4: a level-two entry leaves the enable flag as it was
    p_nmi_mie_r4: assert property (@(posedge clk) disable iff (rst)
        (ack && psw[1:0] == 2'd2) |-> (psw[3] == $past(psw[3])));

    // R3 / R4: every completed entry carries a nonzero level
    p_ack_level_r3: assert property (@(posedge clk) disable iff (rst)
        ack |-> (psw[1:0] != 2'd0));

    // R9: a taken return starts no entry in the same cycle
    p_rti_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && rti_stb && psw[1:0] != 2'd0) |=> !busy);
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .rti_stb (rti_stb),
    .pc      (pc),
    .csr     (csr),
    .psw     (psw),
    .busy    (busy),
    .ack     (ack)
);

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_req = 0, irq_req = 0, swi_stb = 0, rti_stb = 0;
    logic [5:0]  swi_idx = '0;
    logic        arch_we = 0;
    logic [15:0] arch_pc = '0;
    logic [7:0]  arch_csr = '0, arch_psw = '0;
    logic        vt_we = 0;
    logic [5:0]  vt_addr = '0;
    logic [15:0] vt_data = '0;
    logic [15:0] pc;
    logic [7:0]  csr, psw;
    logic        busy, ack;

    int total = 0, bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    irq_entry_seq u_dut (
        .clk(clk), .rst(rst), .nmi_req(nmi_req), .irq_req(irq_req),
        .swi_stb(swi_stb), .swi_idx(swi_idx), .rti_stb(rti_stb),
        .arch_we(arch_we), .arch_pc(arch_pc), .arch_csr(arch_csr),
        .arch_psw(arch_psw), .vt_we(vt_we), .vt_addr(vt_addr),
        .vt_data(vt_data), .pc(pc), .csr(csr), .psw(psw),
        .busy(busy), .ack(ack)
    );

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_pc, m_vec [64], m_elr [2], m_spc;
    logic [7:0]  m_csr, m_psw, m_ecsr [2], m_epsw [2], m_scsr, m_spsw;
    int          m_cnt, m_kind, m_idx, m_psi;
    bit          m_ack, m_pn, m_pm, m_ps;

    always @(posedge clk) begin
        if (rst) begin
            m_pc = 0; m_csr = 0; m_psw = 0; m_cnt = 0; m_ack = 0;
            m_pn = 0; m_pm = 0; m_ps = 0; m_psi = 0; m_kind = 0; m_idx = 0;
            for (int i = 0; i < 64; i++) m_vec[i] = 0;
            for (int b = 0; b < 2; b++) begin m_elr[b] = 0; m_ecsr[b] = 0; m_epsw[b] = 0; end
        end else begin
            bit en, em, es; int ei; int lv;
            en = m_pn | nmi_req; em = m_pm | irq_req; es = m_ps | swi_stb;
            ei = m_ps ? m_psi : int'(swi_idx);
            lv = int'(m_psw[1:0]);
            m_ack = 0;
            m_pn = en; m_pm = em; m_ps = es; m_psi = ei;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_kind == 1) begin
                    if (m_cnt == 1) m_psw[1:0] = 2'd2;
                end else begin
                    if (m_cnt == 2) m_psw[3] = 1'b0;
                    if (m_cnt == 1) m_psw[1:0] = 2'd1;
                end
                if (m_cnt == 0) begin
                    int b; b = (m_kind == 1) ? 1 : 0;
                    m_elr[b] = m_spc; m_ecsr[b] = m_scsr; m_epsw[b] = m_spsw;
                    m_pc = m_vec[m_idx]; m_ack = 1;
                end
            end else if (rti_stb && lv != 0) begin
                int b; b = (lv == 1) ? 0 : 1;
                m_pc = m_elr[b]; m_csr = m_ecsr[b]; m_psw = m_epsw[b];
            end else begin
                bit took; took = 1;
                if (en && lv != 2) begin m_kind = 1; m_idx = 1; m_cnt = 5; m_pn = 0; end
                else if (es) begin m_kind = 2; m_idx = ei; m_cnt = 6; m_ps = 0; end
                else if (em && m_psw[3]) begin m_kind = 0; m_idx = 2; m_cnt = 6; m_pm = 0; end
                else took = 0;
                if (took) begin m_spc = m_pc; m_scsr = m_csr; m_spsw = m_psw; end
                else if (arch_we) begin m_pc = arch_pc; m_csr = arch_csr; m_psw = arch_psw; end
            end
            if (vt_we) m_vec[vt_addr] = vt_data;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R8 timing, all fields)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R8 model pc",   pc,   m_pc);
            chk("R8 model csr",  csr,  m_csr);
            chk("R8 model psw",  psw,  m_psw);
            chk("R8 model busy", busy, (m_cnt > 0));
            chk("R8 model ack",  ack,  m_ack);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic pulse(input bit n, input bit m, input bit s, input bit r, input int idx);
        nmi_req = n; irq_req = m; swi_stb = s; rti_stb = r; swi_idx = 6'(idx);
        @(negedge clk);
        nmi_req = 0; irq_req = 0; swi_stb = 0; rti_stb = 0;
    endtask

    task automatic arch(input int p, input int c, input int s);
        arch_we = 1; arch_pc = 16'(p); arch_csr = 8'(c); arch_psw = 8'(s);
        @(negedge clk);
        arch_we = 0;
    endtask

    task automatic vt(input int a, input int d);
        vt_we = 1; vt_addr = 6'(a); vt_data = 16'(d);
        @(negedge clk);
        vt_we = 0;
    endtask

    task automatic wait_entry(output int n);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            if (ack) break;
            if (busy) n++;
            @(negedge clk);
        end
    endtask

    task automatic quiet(input string tag, input int cycles);
        int seen; seen = 0;
        for (int k = 0; k < cycles; k++) begin
            if (busy) seen++;
            @(negedge clk);
        end
        chk(tag, seen, 0);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 reset pc", pc, 0);
        chk("R1 reset psw", psw, 0);
        chk("R1 reset busy", busy, 0);

        vt(1, 16'h0100); vt(2, 16'h0200); vt(63, 16'h3F3F); vt(0, 16'h0AAA); vt(5, 16'h0505);

        // R2: maskable blocked while enable is 0, held pending
        arch(16'h1234, 8'h5A, 8'h00);
        pulse(0, 1, 0, 0, 0);
        quiet("R2 masked stays idle", 8);
        chk("R2 pc unchanged", pc, 16'h1234);
        arch(16'h1234, 8'h5A, 8'h08);
        @(negedge clk);
        wait_entry(n);
        chk("R3 maskable busy cycles", n, 6);
        chk("R3 maskable pc", pc, 16'h0200);
        chk("R3 maskable psw", psw, 8'h01);
        pulse(0, 0, 0, 1, 0);
        chk("R9 return pc", pc, 16'h1234);
        chk("R9 return csr", csr, 8'h5A);
        chk("R9 return psw pre-update", psw, 8'h08);

        // R4 / R5: non-maskable entry and block at level 2
        pulse(1, 0, 0, 0, 0);
        wait_entry(n);
        chk("R4 nmi busy cycles", n, 5);
        chk("R4 nmi pc", pc, 16'h0100);
        chk("R4 nmi psw keeps enable", psw, 8'h0A);
        pulse(1, 0, 0, 0, 0);
        quiet("R5 nmi blocked at level 2", 8);
        pulse(0, 0, 0, 1, 0);
        chk("R9 bank two return pc", pc, 16'h1234);
        @(negedge clk);
        wait_entry(n);
        chk("R5 pending nmi taken later", pc, 16'h0100);
        pulse(0, 0, 0, 1, 0);
        arch(16'h1234, 8'h5A, 8'h00);
        pulse(1, 0, 0, 0, 0);
        wait_entry(n);
        chk("R4 nmi with enable 0 psw", psw, 8'h02);
        pulse(0, 0, 0, 1, 0);

        // R6: software trigger, table ends
        pulse(0, 0, 1, 0, 63);
        wait_entry(n);
        chk("R6 soft busy cycles", n, 6);
        chk("R6 soft slot 63 pc", pc, 16'h3F3F);
        chk("R6 soft psw", psw, 8'h01);
        pulse(0, 0, 0, 1, 0);
        chk("R6 return psw", psw, 8'h00);
        pulse(0, 0, 1, 0, 0);
        wait_entry(n);
        chk("R6 soft slot 0 pc", pc, 16'h0AAA);
        pulse(0, 0, 0, 1, 0);

        // R9: return at level 0 ignored
        pulse(0, 0, 0, 1, 0);
        chk("R9 level-0 return ignored pc", pc, 16'h1234);
        chk("R9 level-0 return ignored psw", psw, 8'h00);

        // R10 / R9: load and return ignored while busy; table rewrite
        vt(0, 16'h0BBB);
        pulse(0, 0, 1, 0, 0);
        arch(16'hFFFF, 8'hEE, 8'hFF);
        pulse(0, 0, 0, 1, 0);
        wait_entry(n);
        chk("R10 load ignored while busy pc", pc, 16'h0BBB);
        chk("R10 load ignored while busy csr", csr, 8'h5A);
        chk("R9 return ignored while busy psw", psw, 8'h01);
        pulse(0, 0, 0, 1, 0);

        // R7: priority chain
        arch(16'h1234, 8'h5A, 8'h08);
        pulse(1, 1, 1, 0, 5);
        wait_entry(n);
        chk("R7 first served is nmi", pc, 16'h0100);
        @(negedge clk);
        wait_entry(n);
        chk("R7 second served is soft", pc, 16'h0505);
        pulse(0, 0, 0, 1, 0);
        chk("R7 return to nmi handler", pc, 16'h0100);
        @(negedge clk);
        wait_entry(n);
        chk("R7 maskable served last", pc, 16'h0200);
        pulse(0, 0, 0, 1, 0);
        pulse(0, 0, 0, 1, 0);
        chk("R9 nested unwind pc", pc, 16'h1234);
        chk("R9 nested unwind psw", psw, 8'h08);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule